// File: doc/BRIEF.md
# Interconnect Clock-Domain Performance Monitor

This block watches one clock domain of an on-chip interconnect and counts activity on the interface nodes in that domain. It holds a set of 32-bit event counters and one 64-bit cycle counter. Each event counter carries a selector that names one node by its type and ID. In every cycle it adds one when any node that matches the selector raises its event line. Software reaches every register through a plain 32-bit read/write port with byte addresses. Counting stops when a global run bit is clear. Each counter also has its own enable bit.

The enable mask, the interrupt-enable mask and the overflow status each have two addresses: one where writing ones sets bits, one where writing ones clears them. In all three masks the cycle counter takes bit 31 and event counter n takes bit n. When a counter wraps, its overflow flag is set. A single level interrupt is raised while any flagged counter also has its interrupt enabled. The nodes are given to the block as flat vectors: for each node, a type, an ID and an event line.

Top module: `pmu_monitor`

## Requirements
- R1: After reset every counter, type selector, mask and overflow flag is zero, the run bit (0xE04 bit 0) is zero and `irq` is low.
- R2: Event counter n (read/write at 0x008 + 8n) adds exactly one on each clock edge where all of the following hold: the run bit is set, its enable bit n is set, and some node whose type and ID both equal its selector has its event line high.
- R3: A counter does not change while the run bit is clear, while its own enable bit is clear, or while only nodes with a different type or ID raise events.
- R4: The cycle counter adds one on each edge where the run bit and enable bit 31 are both set. It reads as a low word at 0x0F8 and a high word at 0x0FC, each writable on its own. A carry out of the low word increments the high word.
- R5: The selector for counter n is at 0x400 + 4n. It holds a 4-bit node type in bits 12:9 and a 9-bit node ID in bits 8:0, and its other bits read zero. Values written to a counter read back unchanged.
- R6: Count enable is set by writing ones at 0xC00 and cleared by writing ones at 0xC20. Interrupt enable is set at 0xC40 and cleared at 0xC60. Both addresses of a pair read the current mask. Only bits 0..N-1 and bit 31 can be held.
- R7: A counter that wraps from all ones to zero sets its overflow flag. Overflow status reads at 0xC80 and 0xCC0. Writing ones at 0xC80 clears flags and writing ones at 0xCC0 sets them. Only the bits listed in R6 can be held.
- R8: `irq` is high exactly while some counter has both its overflow flag and its interrupt enable set.
- R9: Writing 0xE04 stores bit 0 as the run bit. Writing a one in bit 1 zeroes all event counters and a one in bit 2 zeroes the cycle counter; these bits read back as zero.
- R10: Offset 0x000 reads the unit's node ID in bits 31:16 and its node type in bits 15:0. Offset 0xE00 reads a nonzero configuration word: the counter count in bits 7:0, the value 32 in bits 15:8, and zero above. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| nodeType | input | NUM_NODES*4 | Type of each node, node i at bits [4i+3:4i] |
| nodeId | input | NUM_NODES*9 | ID of each node, node i at bits [9i+8:9i] |
| nodeEvt | input | NUM_NODES | Event line of each node |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses eight event counters and four nodes. Two of the nodes share a type but differ in ID, and two share an ID but differ in type, so a match on half of the selector can be told apart from a full match. The node-info word is set to 0x00210006. Eight counters leave bits 8..30 of every mask unimplemented, which lets the bench check that those bits are dropped. It also preloads values next to a wrap, so the 64-bit carry and the overflow flag are reached within a few cycles.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W   = 32;
  localparam int MAX_CNT  = 31;
  localparam int CYC_BIT  = 31;

  localparam int OFS_INFO   = 'h000;
  localparam int OFS_CNT    = 'h008;
  localparam int OFS_CYC_LO = 'h0F8;
  localparam int OFS_CYC_HI = 'h0FC;
  localparam int OFS_TYPE   = 'h400;
  localparam int OFS_EN_SET = 'hC00;
  localparam int OFS_EN_CLR = 'hC20;
  localparam int OFS_IE_SET = 'hC40;
  localparam int OFS_IE_CLR = 'hC60;
  localparam int OFS_OV_CLR = 'hC80;
  localparam int OFS_OV_SET = 'hCC0;
  localparam int OFS_CFG    = 'hE00;
  localparam int OFS_CTRL   = 'hE04;

  typedef struct packed {
    logic [DATA_W-1:0]  wdata;
    logic [MAX_CNT-1:0] cntWr;
    logic [MAX_CNT-1:0] typeWr;
    logic               cycLoWr;
    logic               cycHiWr;
    logic               enSet;
    logic               enClr;
    logic               ieSet;
    logic               ieClr;
    logic               ovSet;
    logic               ovClr;
    logic               ctrlWr;
  } pmu_strobe_t;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
#(
  parameter int NUM_CNT   = 8,
  parameter int ADDR_W    = 12,
  parameter int SEL_W     = 13,
  parameter logic [15:0] SELF_ID   = 16'h0000,
  parameter logic [15:0] SELF_TYPE = 16'h0006
) (
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NUM_CNT*DATA_W-1:0] cntFlat,
  input  logic [NUM_CNT*SEL_W-1:0]  typeFlat,
  input  logic [63:0]               cyc,
  input  logic [DATA_W-1:0]         cntEn,
  input  logic [DATA_W-1:0]         intEn,
  input  logic [DATA_W-1:0]         ovs,
  input  logic                      globalEn,
  output pmu_strobe_t               strb,
  output logic [DATA_W-1:0]         rdata
);
  localparam logic [DATA_W-1:0] CFG_WORD = {16'h0, 8'd32, 8'(NUM_CNT)};

  // write decode into one-cycle strobes
  always_comb begin
    strb = '0;
    strb.wdata = wdata;
    if (wrEn) begin
      for (int n = 0; n < NUM_CNT; n++) begin
        if (addr == ADDR_W'(OFS_CNT + 8*n))  strb.cntWr[n]  = 1'b1;
        if (addr == ADDR_W'(OFS_TYPE + 4*n)) strb.typeWr[n] = 1'b1;
      end
      case (addr)
        ADDR_W'(OFS_CYC_LO): strb.cycLoWr = 1'b1;
        ADDR_W'(OFS_CYC_HI): strb.cycHiWr = 1'b1;
        ADDR_W'(OFS_EN_SET): strb.enSet   = 1'b1;
        ADDR_W'(OFS_EN_CLR): strb.enClr   = 1'b1;
        ADDR_W'(OFS_IE_SET): strb.ieSet   = 1'b1;
        ADDR_W'(OFS_IE_CLR): strb.ieClr   = 1'b1;
        ADDR_W'(OFS_OV_SET): strb.ovSet   = 1'b1;
        ADDR_W'(OFS_OV_CLR): strb.ovClr   = 1'b1;
        ADDR_W'(OFS_CTRL):   strb.ctrlWr  = 1'b1;
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int n = 0; n < NUM_CNT; n++) begin
      if (addr == ADDR_W'(OFS_CNT + 8*n))  rdata = cntFlat[n*DATA_W +: DATA_W];
      if (addr == ADDR_W'(OFS_TYPE + 4*n)) rdata = DATA_W'(typeFlat[n*SEL_W +: SEL_W]);
    end
    case (addr)
      ADDR_W'(OFS_INFO):   rdata = {SELF_ID, SELF_TYPE};
      ADDR_W'(OFS_CYC_LO): rdata = cyc[31:0];
      ADDR_W'(OFS_CYC_HI): rdata = cyc[63:32];
      ADDR_W'(OFS_EN_SET), ADDR_W'(OFS_EN_CLR): rdata = cntEn;
      ADDR_W'(OFS_IE_SET), ADDR_W'(OFS_IE_CLR): rdata = intEn;
      ADDR_W'(OFS_OV_SET), ADDR_W'(OFS_OV_CLR): rdata = ovs;
      ADDR_W'(OFS_CFG):    rdata = CFG_WORD;
      ADDR_W'(OFS_CTRL):   rdata = {{(DATA_W-1){1'b0}}, globalEn};
      default: ;
    endcase
  end
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
#(
  parameter int NUM_CNT   = 8,
  parameter int NUM_NODES = 4,
  parameter int TYPE_W    = 4,
  parameter int ID_W      = 9
) (
  input  logic                        clk,
  input  logic                        rst,
  input  pmu_strobe_t                 strb,
  input  logic [NUM_NODES*TYPE_W-1:0] nodeType,
  input  logic [NUM_NODES*ID_W-1:0]   nodeId,
  input  logic [NUM_NODES-1:0]        nodeEvt,
  output logic [NUM_CNT*DATA_W-1:0]   cntFlat,
  output logic [NUM_CNT*(TYPE_W+ID_W)-1:0] typeFlat,
  output logic [63:0]                 cyc,
  output logic [DATA_W-1:0]           cntEn,
  output logic [DATA_W-1:0]           intEn,
  output logic [DATA_W-1:0]           ovs,
  output logic                        globalEn,
  output logic [NUM_CNT-1:0]          incEvt,
  output logic                        incCyc
);
  localparam int SEL_W = TYPE_W + ID_W;
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));

  logic evtRst, cycRst;
  logic [NUM_CNT-1:0] wrapEvt;
  logic wrapCyc;
  logic [DATA_W-1:0] wrapVec;

  assign evtRst = strb.ctrlWr & strb.wdata[1];
  assign cycRst = strb.ctrlWr & strb.wdata[2];

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    logic [DATA_W-1:0] cntQ;
    logic [SEL_W-1:0]  selQ;
    logic hit;

    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_NODES; i++) begin
        if (nodeEvt[i] &&
            nodeType[i*TYPE_W +: TYPE_W] == selQ[SEL_W-1:ID_W] &&
            nodeId[i*ID_W +: ID_W] == selQ[ID_W-1:0])
          hit = 1'b1;
      end
    end

    assign incEvt[n]  = globalEn & cntEn[n] & hit;
    assign wrapEvt[n] = incEvt[n] & (&cntQ) & ~strb.cntWr[n] & ~evtRst;

    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        cntQ <= '0;
        selQ <= '0;
      end else begin
        if (strb.cntWr[n])  cntQ <= strb.wdata;
        else if (evtRst)    cntQ <= '0;
        else if (incEvt[n]) cntQ <= cntQ + 1'b1;
        if (strb.typeWr[n]) selQ <= strb.wdata[SEL_W-1:0];
      end
    end

    assign cntFlat[n*DATA_W +: DATA_W] = cntQ;
    assign typeFlat[n*SEL_W +: SEL_W]  = selQ;
  end

  assign incCyc  = globalEn & cntEn[CYC_BIT];
  assign wrapCyc = incCyc & (&cyc) & ~strb.cycLoWr & ~strb.cycHiWr & ~cycRst;

  always_comb begin
    wrapVec = '0;
    wrapVec[NUM_CNT-1:0] = wrapEvt;
    wrapVec[CYC_BIT] = wrapCyc;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cyc      <= '0;
      cntEn    <= '0;
      intEn    <= '0;
      ovs      <= '0;
      globalEn <= 1'b0;
    end else begin
      if (strb.cycLoWr || strb.cycHiWr) begin
        if (strb.cycLoWr) cyc[31:0]  <= strb.wdata;
        if (strb.cycHiWr) cyc[63:32] <= strb.wdata;
      end else if (cycRst) begin
        cyc <= '0;
      end else if (incCyc) begin
        cyc <= cyc + 64'd1;
      end
      if (strb.enSet) cntEn <= (cntEn | strb.wdata) & IMPL_MASK;
      if (strb.enClr) cntEn <= cntEn & ~strb.wdata;
      if (strb.ieSet) intEn <= (intEn | strb.wdata) & IMPL_MASK;
      if (strb.ieClr) intEn <= intEn & ~strb.wdata;
      // hardware wrap wins over a software clear in the same cycle
      ovs <= ((strb.ovSet ? (ovs | strb.wdata) :
               strb.ovClr ? (ovs & ~strb.wdata) : ovs) | wrapVec) & IMPL_MASK;
      if (strb.ctrlWr) globalEn <= strb.wdata[0];
    end
  end
endmodule

// File: rtl/pmu_monitor.sv
module pmu_monitor
  import pmu_pkg::*;
#(
  parameter int NUM_CNT   = 8,
  parameter int NUM_NODES = 4,
  parameter int TYPE_W    = 4,
  parameter int ID_W      = 9,
  parameter int ADDR_W    = 12,
  parameter logic [15:0] SELF_ID   = 16'h0021,
  parameter logic [15:0] SELF_TYPE = 16'h0006
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  input  logic [NUM_NODES*TYPE_W-1:0] nodeType,
  input  logic [NUM_NODES*ID_W-1:0]   nodeId,
  input  logic [NUM_NODES-1:0]        nodeEvt,
  output logic                        irq
);
  localparam int SEL_W = TYPE_W + ID_W;

  pmu_strobe_t strb;
  logic [NUM_CNT*DATA_W-1:0] cntFlat;
  logic [NUM_CNT*SEL_W-1:0]  typeFlat;
  logic [63:0]       cyc;
  logic [DATA_W-1:0] cntEn, intEn, ovs;
  logic              globalEn;
  logic [NUM_CNT-1:0] incEvt;
  logic              incCyc;

  pmu_ctrl #(
    .NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .SELF_ID(SELF_ID), .SELF_TYPE(SELF_TYPE)
  ) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wdata(wdata),
    .cntFlat(cntFlat), .typeFlat(typeFlat), .cyc(cyc),
    .cntEn(cntEn), .intEn(intEn), .ovs(ovs), .globalEn(globalEn),
    .strb(strb), .rdata(rdata)
  );

  pmu_datapath #(
    .NUM_CNT(NUM_CNT), .NUM_NODES(NUM_NODES), .TYPE_W(TYPE_W), .ID_W(ID_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .nodeType(nodeType), .nodeId(nodeId), .nodeEvt(nodeEvt),
    .cntFlat(cntFlat), .typeFlat(typeFlat), .cyc(cyc),
    .cntEn(cntEn), .intEn(intEn), .ovs(ovs), .globalEn(globalEn),
    .incEvt(incEvt), .incCyc(incCyc)
  );

  assign irq = |(ovs & intEn);
endmodule

// File: rtl/pmu_monitor_chk.sv
module pmu_monitor_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      irq,
  input pmu_strobe_t               strb,
  input logic [NUM_CNT*DATA_W-1:0] cntFlat,
  input logic [63:0]               cyc,
  input logic [DATA_W-1:0]         ovs,
  input logic                      globalEn,
  input logic [NUM_CNT-1:0]        incEvt,
  input logic                      incCyc
);
  // R1: reset leaves no flag and no run bit
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ovs == '0 && !globalEn));

  // R3: cycle counter holds while stopped and not written
  a_r3_cyc_hold: assert property (@(posedge clk) disable iff (rst)
    (!globalEn && !strb.cycLoWr && !strb.cycHiWr && !strb.ctrlWr) |=> $stable(cyc));

  // R4: carry from low word into high word
  a_r4_carry: assert property (@(posedge clk) disable iff (rst)
    (incCyc && cyc[31:0] == 32'hFFFF_FFFF && !strb.cycLoWr && !strb.cycHiWr && !strb.ctrlWr)
    |=> (cyc[63:32] == $past(cyc[63:32]) + 32'd1 && cyc[31:0] == 32'd0));

  // R8: interrupt only with some flag raised
  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ovs != '0));

  // R9: cycle reset bit zeroes the cycle counter
  a_r9_cyc_reset: assert property (@(posedge clk) disable iff (rst)
    (strb.ctrlWr && strb.wdata[2] && !strb.cycLoWr && !strb.cycHiWr) |=> (cyc == 64'd0));

  // R7: wrap of an event counter raises its flag
  for (genvar k = 0; k < NUM_CNT; k++) begin : g_wrap
    a_r7_wrap_flag: assert property (@(posedge clk) disable iff (rst)
      (incEvt[k] && cntFlat[k*DATA_W +: DATA_W] == 32'hFFFF_FFFF &&
       !strb.cntWr[k] && !(strb.ctrlWr && strb.wdata[1]))
      |=> (ovs[k] && cntFlat[k*DATA_W +: DATA_W] == 32'd0));
  end
endmodule

bind pmu_monitor pmu_monitor_chk #(.NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .strb(strb), .cntFlat(cntFlat),
  .cyc(cyc), .ovs(ovs), .globalEn(globalEn), .incEvt(incEvt), .incCyc(incCyc)
);

// File: tb/pmu_monitor_tb.sv
module pmu_monitor_tb;
  localparam int NN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NN*4-1:0] nodeType;
  logic [NN*9-1:0] nodeId;
  logic [NN-1:0] nodeEvt = '0;
  logic irq;
  logic probe = 1'b0;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [31:0] expQ[$];
  string tagQ[$];

  // node0 type5 id3, node1 type5 id4, node2 type6 id3, node3 type2 id100
  assign nodeType = {4'd2, 4'd6, 4'd5, 4'd5};
  assign nodeId   = {9'd100, 9'd3, 9'd4, 9'd3};

  always #2.5 clk = ~clk;

  pmu_monitor #(.NUM_CNT(8), .NUM_NODES(NN), .SELF_ID(16'h0021), .SELF_TYPE(16'h0006)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdata(rdata),
    .nodeType(nodeType), .nodeId(nodeId), .nodeEvt(nodeEvt), .irq(irq)
  );

  // monitor: pop expected reads and compare
  always @(negedge clk) begin
    if (probe && expQ.size() > 0) begin
      automatic logic [31:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      nTests++;
      if (rdata !== e) begin
        nFail++;
        $display("FAIL %s addr=0x%03h actual=0x%08h expected=0x%08h", t, addr, rdata, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    addr = a; probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string t);
    nTests++;
    if (irq !== e) begin
      nFail++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic pulse(input logic [NN-1:0] v, input int cycles);
    nodeEvt = v;
    repeat (cycles) begin @(posedge clk); #1; end
    nodeEvt = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;

    // R1 reset state
    rd(12'h008, 32'h0, "R1 counter0");
    rd(12'h0F8, 32'h0, "R1 cycle lo");
    rd(12'hC00, 32'h0, "R1 enable");
    rd(12'hC80, 32'h0, "R1 overflow");
    rd(12'hE04, 32'h0, "R1 ctrl");
    chkIrq(1'b0, "R1 irq");

    // R10 identity, config and holes
    rd(12'h000, 32'h0021_0006, "R10 info");
    rd(12'hE00, 32'h0000_2008, "R10 cfg");
    rd(12'h004, 32'h0, "R10 hole 004");
    rd(12'h500, 32'h0, "R10 hole 500");

    // R5 readback
    wr(12'h030, 32'h1234_5678);
    rd(12'h030, 32'h1234_5678, "R5 counter5");
    wr(12'h41C, 32'hFFFF_FFFF);
    rd(12'h41C, 32'h0000_1FFF, "R5 selector7");

    // R6 masks
    wr(12'hC00, 32'hFFFF_FFFF);
    rd(12'hC00, 32'h8000_00FF, "R6 set view");
    rd(12'hC20, 32'h8000_00FF, "R6 clr view");
    wr(12'hC20, 32'h0000_000F);
    rd(12'hC00, 32'h8000_00F0, "R6 partial clear");
    wr(12'hC20, 32'hFFFF_FFFF);
    rd(12'hC00, 32'h0, "R6 full clear");

    // R2 / R3 event matching
    wr(12'h400, 32'h0000_0A03);
    wr(12'h404, 32'h0000_0C03);
    wr(12'hC00, 32'h0000_0003);
    wr(12'hE04, 32'h1);
    pulse(4'b0001, 3);
    pulse(4'b0100, 2);
    pulse(4'b0010, 4);
    wr(12'hE04, 32'h0);
    pulse(4'b0001, 2);
    rd(12'h008, 32'd3, "R2 counter0 full match");
    rd(12'h010, 32'd2, "R2 counter1 full match");
    rd(12'h018, 32'd0, "R3 counter2 disabled");
    wr(12'hC20, 32'h1);
    wr(12'hE04, 32'h1);
    pulse(4'b0001, 2);
    wr(12'hE04, 32'h0);
    rd(12'h008, 32'd3, "R3 counter0 own enable off");
    rd(12'h010, 32'd2, "R3 counter1 no match");

    // R4 cycle counter with carry
    wr(12'hE04, 32'h4);
    wr(12'h0F8, 32'hFFFF_FFFE);
    wr(12'h0FC, 32'h0000_0005);
    wr(12'hC00, 32'h8000_0000);
    wr(12'hE04, 32'h1);
    repeat (2) begin @(posedge clk); #1; end
    wr(12'hE04, 32'h0);
    rd(12'h0F8, 32'h1, "R4 low word");
    rd(12'h0FC, 32'h6, "R4 high word carry");
    repeat (3) begin @(posedge clk); #1; end
    rd(12'h0F8, 32'h1, "R3 cycle stopped");

    // R9 control resets
    wr(12'hE04, 32'h2);
    rd(12'h008, 32'h0, "R9 event reset c0");
    rd(12'h030, 32'h0, "R9 event reset c5");
    rd(12'h0F8, 32'h1, "R9 cycle untouched");
    wr(12'hE04, 32'h4);
    rd(12'h0F8, 32'h0, "R9 cycle reset lo");
    rd(12'h0FC, 32'h0, "R9 cycle reset hi");
    rd(12'hE04, 32'h0, "R9 ctrl read");
    wr(12'hE04, 32'h7);
    rd(12'hE04, 32'h1, "R9 ctrl only run bit");
    wr(12'hE04, 32'h4);

    // R7 / R8 overflow and interrupt
    wr(12'h408, 32'h0000_0464);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'hC00, 32'h4);
    wr(12'hC40, 32'h4);
    chkIrq(1'b0, "R8 no flag");
    wr(12'hE04, 32'h1);
    pulse(4'b1000, 1);
    wr(12'hE04, 32'h4);
    rd(12'h018, 32'h0, "R7 wrapped counter");
    rd(12'hC80, 32'h4, "R7 flag set");
    chkIrq(1'b1, "R8 irq raised");
    wr(12'hC60, 32'h4);
    chkIrq(1'b0, "R8 irq masked");
    rd(12'hC80, 32'h4, "R7 flag kept");
    wr(12'hC80, 32'h4);
    rd(12'hC80, 32'h0, "R7 flag cleared");
    wr(12'hCC0, 32'h8000_0000);
    rd(12'hCC0, 32'h8000_0000, "R7 software set");
    chkIrq(1'b0, "R8 bit31 not enabled");
    wr(12'hC40, 32'h8000_0000);
    chkIrq(1'b1, "R8 cycle flag irq");
    wr(12'hC80, 32'hFFFF_FFFF);
    chkIrq(1'b0, "R8 all cleared");
    wr(12'hCC0, 32'hFFFF_FFFF);
    rd(12'hC80, 32'h8000_00FF, "R7 only held bits");

    wait (expQ.size() == 0);
    @(posedge clk); #1;
    finishRun();
  end
endmodule